// File: doc/BRIEF.md
# Auto-Reload Down Timer with Output Shaping

This block is a single down-counting timer sitting on a small local register bus. It has four 32-bit registers: the running count, a reload value, a command word and a status word. Software sets the reload value and copies it into the count with a one-shot Load strobe. Enable then makes the count fall by one on every 50 MHz clock, which gives a 20 ns step. When the count reaches zero the block raises a sticky TimeOut flag. It also emits a one-clock event toward an interrupt controller. With automatic reload turned on, the count restarts from the reload value and the timer keeps running.

The single output pin has three uses. It can invert on every timeout, which gives a square wave at 25 MHz/(SET+1). It can give one clock-wide high pulse per timeout, which gives a rate of 50 MHz/(SET+1). It can also ignore the timer completely and be driven as a plain general-purpose output from a command bit.

Register decode uses address bits [3:2]. Bus writes take effect at the clock edge where the write strobe is sampled. Reads are combinational from the address.

Top module: `dtmr_top`

## Requirements
- R1: After reset, the current count (offset 0x0) reads 0x00000000, the reload value (0x4) reads 0xFFFFFFFF, the command word (0x8) and status (0xC) read 0, and both the output pin and the event output are low.
- R2: The command word keeps bit 0 Enable, bit 2 Auto, bit 3 Alt, bit 4 OutSel and bit 5 OutVal. Bit 1 Clear and bit 7 Load are strobes that read back 0, and every other bit reads 0. Writes to offset 0x0 or offset 0xC change nothing.
- R3: While Enable is 1, the count decreases by one on each clock edge, starting with the edge after the edge at which Enable was written. While Enable is 0, the count holds its value.
- R4: A command write with Load set copies the reload value into the count. A command write with Clear set zeroes the count. If both are set in the same write, Load wins. Both strobes clear the TimeOut flag.
- R5: When the count steps from 1 to 0, tmo_evt is high for exactly the one cycle in which the count reads 0. In that same cycle status bit 0 (TimeOut) becomes 1, and it stays 1 until a Load or Clear strobe.
- R6: With Auto at 0, the count stays at zero after a timeout and no further events occur.
- R7: With Auto at 1, a count of zero reloads the reload value on the next enabled edge. Timeouts therefore repeat every SET+1 cycles, and the first one comes SET cycles after a Load. Reloading from a cleared count of zero does not produce an event.
- R8: With OutSel=0 and Alt=0, the output pin inverts in each cycle where tmo_evt is high and otherwise keeps its level.
- R9: With OutSel=0 and Alt=1, the output pin is high exactly in the cycles where tmo_evt is high.
- R10: With OutSel=1, the output pin equals OutVal whatever the timer is doing.
- R11: A reload value of 1 gives the shortest interval, one timeout every 2 cycles (40 ns at 50 MHz).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| tmr_pin | output | 1 | Shaped timer output or software-driven level |
| tmo_evt | output | 1 | One-cycle timeout event for the interrupt controller |

## Verification
A faulty count shows up at the ports within one cycle. The count register can be read back at any time, and an off-by-one in the decrement or the reload moves every later tmo_evt pulse by one cycle. Sweeping several small reload values makes such a shift appear within the first or second period. A wrong toggle state or mode select corrupts tmr_pin in the cycle of the next timeout. Strobe priority and sticky-flag mistakes appear on the very next status or count read after the offending command write.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   typedef enum logic [1:0] {
      SEL_CUR = 2'd0,
      SEL_SET = 2'd1,
      SEL_CMD = 2'd2,
      SEL_STS = 2'd3
   } dtmr_sel_e;

   localparam int B_EN   = 0;
   localparam int B_CLR  = 1;
   localparam int B_AUTO = 2;
   localparam int B_ALT  = 3;
   localparam int B_OSEL = 4;
   localparam int B_OVAL = 5;
   localparam int B_LOAD = 7;

   typedef struct packed {
      logic en;
      logic auto_rl;
      logic alt;
      logic osel;
      logic oval;
   } dtmr_cfg_t;
endpackage

// File: rtl/dtmr_regs.sv
module dtmr_regs
   import dtmr_pkg::*;
#(
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 4,
   parameter logic [DATA_W-1:0] SET_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] cur_val,
   input  logic              tmo_flag,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] set_val,
   output dtmr_cfg_t         cfg,
   output logic              load_stb,
   output logic              clr_stb
);
   dtmr_sel_e sel;
   logic      hit;
   logic      wr_set, wr_cmd;

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("dtmr_regs: DATA_W must hold the command bits");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("dtmr_regs: ADDR_W must cover four word registers");
      end
      if (ADDR_W > 4) begin : g_wide_addr
         assign hit = (reg_addr[ADDR_W-1:4] == '0);
      end else begin : g_exact_addr
         assign hit = 1'b1;
      end
   endgenerate

   assign sel      = dtmr_sel_e'(reg_addr[3:2]);
   assign wr_set   = reg_wr && hit && (sel == SEL_SET);
   assign wr_cmd   = reg_wr && hit && (sel == SEL_CMD);
   assign load_stb = wr_cmd && reg_wdata[B_LOAD];
   assign clr_stb  = wr_cmd && reg_wdata[B_CLR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         set_val <= SET_INIT;
         cfg     <= '0;
      end else begin
         if (wr_set) set_val <= reg_wdata;
         if (wr_cmd) begin
            cfg.en      <= reg_wdata[B_EN];
            cfg.auto_rl <= reg_wdata[B_AUTO];
            cfg.alt     <= reg_wdata[B_ALT];
            cfg.osel    <= reg_wdata[B_OSEL];
            cfg.oval    <= reg_wdata[B_OVAL];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (hit) begin
         unique case (sel)
            SEL_CUR: reg_rdata = cur_val;
            SEL_SET: reg_rdata = set_val;
            SEL_CMD: begin
               reg_rdata[B_EN]   = cfg.en;
               reg_rdata[B_AUTO] = cfg.auto_rl;
               reg_rdata[B_ALT]  = cfg.alt;
               reg_rdata[B_OSEL] = cfg.osel;
               reg_rdata[B_OVAL] = cfg.oval;
            end
            SEL_STS: reg_rdata[0] = tmo_flag;
            default: reg_rdata = '0;
         endcase
      end
   end

   // R2
   strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && sel == SEL_CMD) |-> (reg_rdata[B_LOAD] == 1'b0 && reg_rdata[B_CLR] == 1'b0));

   // R2
   set_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (set_val == $past(reg_wdata)));
endmodule

// File: rtl/dtmr_core.sv
module dtmr_core #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              auto_rl,
   input  logic              load_stb,
   input  logic              clr_stb,
   input  logic [DATA_W-1:0] set_val,
   output logic [DATA_W-1:0] cur_val,
   output logic              tick,
   output logic              evt,
   output logic              tmo_flag
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic strobe;
   logic at_zero;

   assign strobe  = load_stb || clr_stb;
   assign at_zero = (cur_val == '0);
   assign tick    = en && !strobe && (cur_val == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_val <= '0;
      end else if (load_stb) begin
         cur_val <= set_val;
      end else if (clr_stb) begin
         cur_val <= '0;
      end else if (en) begin
         if (!at_zero)     cur_val <= cur_val - ONE;
         else if (auto_rl) cur_val <= set_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt      <= 1'b0;
         tmo_flag <= 1'b0;
      end else begin
         evt <= tick;
         if (strobe)    tmo_flag <= 1'b0;
         else if (tick) tmo_flag <= 1'b1;
      end
   end

   // R5
   evt_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (cur_val == '0));

   // R5
   flag_with_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> tmo_flag);

   // R3
   hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !strobe) |=> $stable(cur_val));

   // R4
   load_copies_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |=> (cur_val == $past(set_val)));

   // R6
   oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_zero && !auto_rl && !strobe) |=> (cur_val == '0));
endmodule

// File: rtl/dtmr_out.sv
module dtmr_out #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic evt,
   input  logic alt,
   input  logic osel,
   input  logic oval,
   output logic pin
);
   logic tgl;
   logic pin_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tgl <= 1'b0;
      else if (tick) tgl <= ~tgl;
   end

   always_comb begin
      if (osel)     pin_d = oval;
      else if (alt) pin_d = evt;
      else          pin_d = tgl;
   end

   generate
      if (OUT_REG) begin : g_reg_pin
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pin <= 1'b0;
            else        pin <= pin_d;
         end
      end else begin : g_comb_pin
         assign pin = pin_d;
      end
   endgenerate

   // R8
   toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (tgl != $past(tgl)));

   // R8
   toggle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(tgl));
endmodule

// File: rtl/dtmr_top.sv
module dtmr_top
   import dtmr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 4,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              tmr_pin,
   output logic              tmo_evt
);
   dtmr_cfg_t         cfg;
   logic [DATA_W-1:0] set_val;
   logic [DATA_W-1:0] cur_val;
   logic              load_stb, clr_stb;
   logic              tick, evt, tmo_flag;

   dtmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .cur_val   (cur_val),
      .tmo_flag  (tmo_flag),
      .reg_rdata (reg_rdata),
      .set_val   (set_val),
      .cfg       (cfg),
      .load_stb  (load_stb),
      .clr_stb   (clr_stb)
   );

   dtmr_core #(.DATA_W(DATA_W)) core_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg.en),
      .auto_rl  (cfg.auto_rl),
      .load_stb (load_stb),
      .clr_stb  (clr_stb),
      .set_val  (set_val),
      .cur_val  (cur_val),
      .tick     (tick),
      .evt      (evt),
      .tmo_flag (tmo_flag)
   );

   dtmr_out #(.OUT_REG(OUT_REG)) out_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .evt   (evt),
      .alt   (cfg.alt),
      .osel  (cfg.osel),
      .oval  (cfg.oval),
      .pin   (tmr_pin)
   );

   assign tmo_evt = evt;

   // R9
   pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!OUT_REG && !cfg.osel && cfg.alt) |-> (tmr_pin == tmo_evt));
endmodule

// File: tb/dtmr_top_tb_top.sv
module dtmr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tmr_pin;
   logic        tmo_evt;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   dtmr_top dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .tmr_pin   (tmr_pin),
      .tmo_evt   (tmo_evt)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   // drive at negedge, commit at posedge, return at the following negedge
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   // run k = 1..n cycles after a load write; timeouts at k = s + m*(s+1)
   task automatic sweep(input int s, input bit pulse, input int n, input string tag);
      logic t0;
      int   cnt;
      bit   e;
      t0  = tmr_pin;
      cnt = 0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         e = (k >= s) && (((k - s) % (s + 1)) == 0);
         if (e) cnt++;
         check({tag, " evt"}, {31'd0, tmo_evt}, {31'd0, e});
         if (pulse) check("R9 pulse pin", {31'd0, tmr_pin}, {31'd0, e});
         else       check("R8 toggle pin", {31'd0, tmr_pin}, {31'd0, t0 ^ cnt[0]});
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'h0, v); check("R1 cur", v, 32'h0);
      rd(4'h4, v); check("R1 set", v, 32'hFFFF_FFFF);
      rd(4'h8, v); check("R1 cmd", v, 32'h0);
      rd(4'hC, v); check("R1 sts", v, 32'h0);
      check("R1 pin", {31'd0, tmr_pin}, 32'h0);
      check("R1 evt", {31'd0, tmo_evt}, 32'h0);

      // R2 map, readback masking, ignored writes
      wr(4'h0, 32'h55);       rd(4'h0, v); check("R2 cur write ignored", v, 32'h0);
      wr(4'hC, 32'h1);        rd(4'hC, v); check("R2 sts write ignored", v, 32'h0);
      wr(4'h4, 32'h1234);     rd(4'h4, v); check("R2 set readback", v, 32'h1234);
      wr(4'h8, 32'hFFFF_FF7C); rd(4'h8, v); check("R2 cmd mask", v, 32'h3C);
      check("R10 gpio high", {31'd0, tmr_pin}, 32'h1);
      wr(4'h8, 32'h18);
      check("R10 gpio low", {31'd0, tmr_pin}, 32'h0);
      wr(4'h8, 32'h0);

      // R3 hold while disabled, count while enabled
      wr(4'h4, 32'd100);
      wr(4'h8, 32'h80);
      rd(4'h0, v); check("R4 load", v, 32'd100);
      repeat (5) @(negedge clk);
      rd(4'h0, v); check("R3 hold", v, 32'd100);
      wr(4'h8, 32'h01);
      rd(4'h0, v); check("R3 first edge", v, 32'd100);
      repeat (5) @(negedge clk);
      rd(4'h0, v); check("R3 count", v, 32'd95);
      wr(4'h8, 32'h00);

      // R4 priority
      wr(4'h8, 32'h02); rd(4'h0, v); check("R4 clear", v, 32'd0);
      wr(4'h8, 32'h82); rd(4'h0, v); check("R4 load wins", v, 32'd100);

      // R5 / R6 one-shot
      wr(4'h4, 32'd3);
      wr(4'h8, 32'h81);
      sweep(3, 1'b0, 3, "R5");
      rd(4'hC, v); check("R5 flag set", v, 32'h1);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         check("R6 no repeat", {31'd0, tmo_evt}, 32'h0);
      end
      rd(4'h0, v); check("R6 held zero", v, 32'h0);
      wr(4'h8, 32'h01); rd(4'hC, v); check("R5 flag sticky", v, 32'h1);
      wr(4'h8, 32'h02); rd(4'hC, v); check("R5 flag cleared", v, 32'h0);

      // R7 / R8 toggle sweep, R11 at s=1
      for (int s = 1; s <= 8; s++) begin
         wr(4'h8, 32'h00);
         wr(4'h4, s);
         wr(4'h8, 32'h85);
         sweep(s, 1'b0, 4 * (s + 1), s == 1 ? "R11" : "R7");
      end

      // R9 pulse sweep
      for (int s = 1; s <= 6; s++) begin
         wr(4'h8, 32'h00);
         wr(4'h4, s);
         wr(4'h8, 32'h8D);
         sweep(s, 1'b1, 3 * (s + 1), "R9");
      end

      // R10 gpio overrides a running timer
      wr(4'h8, 32'h3D);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         check("R10 pin follows OutVal", {31'd0, tmr_pin}, 32'h1);
      end

      // R7 reload from cleared zero, no event
      wr(4'h8, 32'h02);
      wr(4'h4, 32'd4);
      wr(4'h8, 32'h05);
      @(negedge clk);
      rd(4'h0, v); check("R7 reload from zero", v, 32'd4);
      check("R7 no evt on reload", {31'd0, tmo_evt}, 32'h0);
      repeat (4) @(negedge clk);
      check("R7 evt after reload", {31'd0, tmo_evt}, 32'h1);
      wr(4'h8, 32'h00);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule